// File: doc/BRIEF.md
# Dithered High-Resolution Numerically Controlled Oscillator

This block is a numerically controlled oscillator whose phase register is 48 bits wide but whose tuning word is 64 bits wide. The upper 48 bits of the tuning word are the base step added to the phase every clock. The lower 16 bits are a fraction, and a free-running 16-bit dither counter turns that fraction into a duty cycle. For the first `fraction` clocks of every 65536-clock dither period the step is one larger than the base. Averaged over a whole period, the phase therefore advances by `65536*base + fraction`, which gives 64-bit frequency resolution from a 48-bit adder.

Software or a control loop presents a tuning word with a one-cycle load strobe. A small controller keeps the word as pending and moves it into the applied word only at the end of a dither period. This means no period is ever dithered with a mixture of two fractions. The outputs are the phase itself, its most significant bit as a square wave, and a one-cycle carry pulse each time the phase wraps. The carry pulse can drive a divider, for example a one-pulse-per-second chain.

The controller has two states. `ST_RUN` means no word is waiting. `ST_ARMED` means a loaded word is waiting for the period boundary. The transitions are:
- `ST_RUN` to `ST_ARMED` on a load.
- `ST_ARMED` to `ST_RUN` at the period boundary when no new load arrives in that cycle.
- `ST_ARMED` to `ST_ARMED` on a further load, or while waiting for the boundary.

Top module: `nco_dither`

## Requirements
- R1: Reset clears the phase, the carry, the dither counter, the pending word and the applied word. Until a loaded word has been applied, the phase stays at zero.
- R2: On every clock after reset, the phase becomes `(phase + step) mod 2^ACC_W`. The step is the applied base (tuning word bits `[ACC_W+FRAC_W-1:FRAC_W]`) plus a dither bit of 0 or 1.
- R3: The dither counter counts clocks from the start of each `2^FRAC_W`-clock period, starting at 0. The dither bit is 1 exactly when this count is less than the applied fraction (tuning word bits `[FRAC_W-1:0]`).
- R4: Over one complete dither period, the phase advances by `(2^FRAC_W * base + fraction) mod 2^ACC_W`.
- R5: With a fraction of zero, every step equals the base.
- R6: A word taken in by the load strobe becomes the applied word at the first period boundary after the load edge. The boundary is the edge that ends count `2^FRAC_W-1`. Until then the previous word keeps stepping the phase.
- R7: If several loads arrive before a boundary, only the last one is applied at that boundary.
- R8: `carry` is high for exactly the cycle after an update whose sum reached `2^ACC_W`. It is low after every other update.
- R9: `sq_out` always equals the most significant bit of `phase`.
- R10: With an all-ones base and a nonzero fraction, a step of `2^ACC_W` leaves the phase unchanged and raises `carry`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | ACC_W+FRAC_W | Tuning word: base in the upper ACC_W bits, fraction in the lower FRAC_W bits |
| tune_load | input | 1 | One-cycle strobe that captures `tune_word` as pending |
| phase | output | ACC_W | Phase register |
| sq_out | output | 1 | Square wave, the phase MSB |
| carry | output | 1 | One-cycle pulse on phase wrap |

## Verification
The bench uses a 12-bit phase with a 4-bit fraction. It sweeps every fraction against a zero base, a base of one, a mid-range base and an all-ones base, and checks each cycle's step and carry as well as each period's total advance. A design with the dither compare off by one would give a period total that is one too large or one too small. A design that applied a new word at once, instead of at the boundary, would show the new step inside a period that started with the old one. The all-ones base catches a carry that is lost when the step equals the full modulus. A double load inside one period catches a controller that keeps the first word instead of the last.

// File: rtl/nco_dither_pkg.sv
package nco_dither_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ARMED = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/nco_word_ctrl.sv
module nco_word_ctrl
    import nco_dither_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load,
    input  logic              wrap,
    output logic [WORD_W-1:0] act_word,
    output ctl_state_t        state_o
);
    ctl_state_t        state_q;
    ctl_state_t        state_d;
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] act_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (load) state_d = ST_ARMED;
            ST_ARMED: if (wrap && !load) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // word holding: apply old pending first, then capture the new one
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (state_q == ST_ARMED && wrap) act_q <= pend_q;
            if (load) pend_q <= word_in;
        end
    end

    // outputs
    always_comb begin
        act_word = act_q;
        state_o  = state_q;
    end
endmodule

// File: rtl/nco_pwm_dither.sv
module nco_pwm_dither #(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAC_W-1:0] frac,
    output logic [FRAC_W-1:0] cnt,
    output logic              wrap,
    output logic              dith
);
    localparam logic [FRAC_W-1:0] CNT_LAST = '1;

    logic [FRAC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cnt  = cnt_q;
        wrap = (cnt_q == CNT_LAST);
        dith = (cnt_q < frac);
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] base,
    input  logic             dith,
    output logic [ACC_W-1:0] phase,
    output logic             carry
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] phase_q;
    logic             carry_q;

    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, base} + SUM_W'(dith);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            carry_q <= 1'b0;
        end else begin
            phase_q <= sum[ACC_W-1:0];
            carry_q <= sum[ACC_W];
        end
    end

    always_comb begin
        phase = phase_q;
        carry = carry_q;
    end
endmodule

// File: rtl/nco_dither.sv
module nco_dither
    import nco_dither_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W+FRAC_W-1:0] tune_word,
    input  logic                    tune_load,
    output logic [ACC_W-1:0]        phase,
    output logic                    sq_out,
    output logic                    carry
);
    localparam int WORD_W = ACC_W + FRAC_W;

    logic [WORD_W-1:0] act_word;
    ctl_state_t        ctl_state;
    logic [FRAC_W-1:0] pwm_cnt;
    logic              pwm_wrap;
    logic              dith;

    nco_word_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .word_in  (tune_word),
        .load     (tune_load),
        .wrap     (pwm_wrap),
        .act_word (act_word),
        .state_o  (ctl_state)
    );

    nco_pwm_dither #(.FRAC_W(FRAC_W)) u_pwm (
        .clk  (clk),
        .rst  (rst),
        .frac (act_word[FRAC_W-1:0]),
        .cnt  (pwm_cnt),
        .wrap (pwm_wrap),
        .dith (dith)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .base  (act_word[WORD_W-1:FRAC_W]),
        .dith  (dith),
        .phase (phase),
        .carry (carry)
    );

    assign sq_out = phase[ACC_W-1];
endmodule

// File: rtl/nco_dither_chk.sv
module nco_dither_chk
    import nco_dither_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tune_load,
    input logic [ACC_W-1:0]        phase,
    input logic                    carry,
    input logic [FRAC_W-1:0]       pwm_cnt,
    input logic [ACC_W+FRAC_W-1:0] act_word,
    input ctl_state_t              ctl_state
);
    localparam logic [FRAC_W-1:0] CNT_LAST = '1;

    // R3: dither counter advances by one every clock
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pwm_cnt == FRAC_W'($past(pwm_cnt) + 1'b1));

    // R6: applied word changes only on the edge ending the last count
    p_apply_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(act_word)) |-> $past(pwm_cnt) == CNT_LAST);

    // R6: a load always leaves a word waiting
    p_load_arms_r6: assert property (@(posedge clk) disable iff (rst)
        tune_load |=> ctl_state == ST_ARMED);

    // R8: a wrap never moves the phase forward
    p_carry_wraps_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && carry) |-> phase <= $past(phase));

    // R8: without a carry the phase never moves backward
    p_no_carry_up_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !carry) |-> phase >= $past(phase));
endmodule

bind nco_dither nco_dither_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tune_load (tune_load),
    .phase     (phase),
    .carry     (carry),
    .pwm_cnt   (pwm_cnt),
    .act_word  (act_word),
    .ctl_state (ctl_state)
);

// File: tb/nco_dither_tb.sv
module nco_dither_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int FW = 4;
    localparam int WW = AW + FW;
    localparam int PER = 1 << FW;
    localparam int MOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] tune_word = '0;
    logic          tune_load = 1'b0;
    logic [AW-1:0] phase;
    logic          sq_out;
    logic          carry;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench-side model of the requirements
    int    ecount   = 0;
    int    m_act    = 0;
    int    m_pend   = 0;
    bit    m_armed  = 0;
    int    per_start = 0;
    int    per_word  = 0;
    string extra_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_dither #(.ACC_W(AW), .FRAC_W(FW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tune_word (tune_word),
        .tune_load (tune_load),
        .phase     (phase),
        .sq_out    (sq_out),
        .carry     (carry)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at time %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        int prev = int'(phase);
        int c    = ecount % PER;
        int base = m_act >> FW;
        int frac = m_act % PER;
        int inc  = base + ((c < frac) ? 1 : 0);
        int sum  = prev + inc;
        int exp_ph = sum % MOD;
        int exp_c  = (sum >= MOD) ? 1 : 0;
        bit ld = tune_load;
        int wd = int'(tune_word);
        string tag;
        if (extra_tag != "")      tag = extra_tag;
        else if (m_armed)         tag = "R2/R6";
        else if (frac == 0)       tag = "R2/R5";
        else if (base == MOD - 1) tag = "R2/R10";
        else                      tag = "R2/R3";
        if (c == 0) begin
            per_start = prev;
            per_word  = m_act;
        end
        @(posedge clk);
        if (m_armed && c == PER - 1) m_act = m_pend;
        if (ld) begin
            m_pend  = wd;
            m_armed = 1;
        end else if (c == PER - 1) begin
            m_armed = 0;
        end
        ecount++;
        @(negedge clk);
        check(int'(phase) == exp_ph, tag, int'(phase), exp_ph);
        check(int'(carry) == exp_c, (base == MOD - 1 && frac != 0) ? "R8/R10" : "R8", int'(carry), exp_c);
        check(int'(sq_out) == ((exp_ph >> (AW - 1)) & 1), "R9", int'(sq_out), (exp_ph >> (AW - 1)) & 1);
        if (c == PER - 1) begin
            int tot = (per_start + PER * (per_word >> FW) + (per_word % PER)) % MOD;
            check(int'(phase) == tot, "R4", int'(phase), tot);
        end
    endtask

    task automatic load_word(input int w);
        tune_word = WW'(w);
        tune_load = 1'b1;
        step();
        tune_load = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(phase == '0, "R1", int'(phase), 0);
        check(carry == 1'b0, "R1", int'(carry), 0);
        rst = 1'b0;
        ecount  = 0;
        m_act   = 0;
        m_pend  = 0;
        m_armed = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int bases[4] = '{0, 1, 'h5A3, MOD - 1};
        @(negedge clk);
        do_reset();
        // R1: no applied word yet, phase must stay at zero
        extra_tag = "R1";
        repeat (20) step();
        extra_tag = "";
        foreach (bases[b]) begin
            for (int f = 0; f < PER; f++) begin
                load_word((bases[b] << FW) | f);
                repeat (2 * PER + 2) step();
            end
        end
        // R7: two loads inside one period, only the second may be applied
        while (ecount % PER != 3) step();
        load_word((12'h0F1 << FW) | 5);
        step();
        load_word((12'h2C7 << FW) | 11);
        extra_tag = "R7";
        repeat (3 * PER) step();
        extra_tag = "";
        check(m_act == ((12'h2C7 << FW) | 11), "R7", m_act, (12'h2C7 << FW) | 11);
        // R1: reset in the middle of a run clears everything again
        repeat (5) step();
        do_reset();
        extra_tag = "R1";
        repeat (PER + 3) step();
        extra_tag = "";
        load_word((12'h7FF << FW) | 9);
        repeat (3 * PER) step();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule